// File: doc/BRIEF.md
# Gated Frequency Counter Controller

The block measures how often an asynchronous input signal rises over a fixed gate interval of one second and presents the result as eight packed BCD digits. A one-hertz tick, already aligned to the system clock, paces a small controller. The controller opens a counting gate for one tick interval and keeps it closed for the next. While the gate is closed it pulses a load strobe for one cycle and then a clear for one cycle. The count therefore equals the input frequency in hertz, and the design is meant for inputs from about 15 Hz up to 10 MHz.

The input passes through a synchronizer and a rising-edge detector. Each detected edge steps a ripple chain of decimal digit counters while the gate is open. The load strobe copies the chain into an output register. That register keeps its value through the clear and the closed phase, so a display fed from it shows a steady number. When the chain reaches all nines it stays there and does not wrap.

The controller has five named states. IDLE follows reset and moves to GATE on a tick. GATE holds the gate open and moves to LOAD on the next tick. LOAD lasts one cycle and always moves to CLEAR. CLEAR lasts one cycle and always moves to REST. REST moves to GATE on a tick. A tick that arrives in LOAD or CLEAR has no effect.

Top module: `freq_gate_meter`

## Requirements
- R1: While reset is asserted and after it is released, `result` is zero and `gate_en`, `load_strobe` and `clear_cnt` are low. They stay low until the first tick arrives.
- R2: A tick in IDLE or REST raises `gate_en` on the next clock edge. It stays high until the clock edge that follows the next tick.
- R3: On the edge where `gate_en` falls, `load_strobe` goes high for exactly one cycle, and `clear_cnt` is low during that cycle.
- R4: `clear_cnt` is high for exactly the one cycle after `load_strobe`. It is low again, with `gate_en` still low, on the following cycle.
- R5: Rising edges of `sig_in` are counted only while `gate_en` is high. Edges in the closed phase do not affect the next result.
- R6: After the load, `result` holds the number of rising edges seen in the gate, as 8421 BCD. Digit k occupies bits [4k+3:4k], and digit 0 is the least significant.
- R7: `result` changes only on the clock edge at the end of a `load_strobe` cycle. It keeps its value through the clear, the closed phase and the next gate.
- R8: Each digit counts from 0 to 9 and wraps to 0. On that wrap it passes a carry to the next digit for a single cycle, so counts such as 10, 100 and 1009 come out correct.
- R9: A count that would go past all nines (99999999 with eight digits) saturates at all nines.
- R10: Each low-to-high change of `sig_in` is counted exactly once, whether it stays high for one cycle or for many.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| sig_in | input | 1 | Signal being measured, asynchronous |
| tick_1hz | input | 1 | One-cycle pulse per second, synchronous to clk |
| gate_en | output | 1 | Count enable, high during the gate second |
| load_strobe | output | 1 | One-cycle strobe that copies the count into `result` |
| clear_cnt | output | 1 | One-cycle clear of the digit counters |
| result | output | 4*DIGITS | Latched count as packed BCD digits |

## Verification
The assertions assume that `tick_1hz` is a clean single-cycle pulse in the clock domain and that ticks arrive far enough apart for LOAD and CLEAR to finish before the next one. They also assume that each high or low phase of `sig_in` lasts at least one clock, so the synchronizer sees every edge. The stimulus spaces ticks by at least several cycles, as at a real one-second pace, and gives every pulse of `sig_in` at least one clock of high time and three clocks of low time. It also keeps the pulses a few cycles away from gate boundaries, so that which gate an edge falls in never depends on synchronizer latency.

// File: rtl/fgm_pkg.sv
package fgm_pkg;
    typedef enum logic [2:0] {
        ST_IDLE,
        ST_GATE,
        ST_LOAD,
        ST_CLEAR,
        ST_REST
    } fgm_state_t;
endpackage

// File: rtl/fgm_gate_ctrl.sv
module fgm_gate_ctrl
    import fgm_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic tick,
    output logic gate,
    output logic load,
    output logic clr
);
    fgm_state_t state_q, state_d;

    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:  if (tick) state_d = ST_GATE;
            ST_GATE:  if (tick) state_d = ST_LOAD;
            ST_LOAD:  state_d = ST_CLEAR;
            ST_CLEAR: state_d = ST_REST;
            ST_REST:  if (tick) state_d = ST_GATE;
            default:  state_d = ST_IDLE;
        endcase
    end

    always_comb begin
        gate = 1'b0;
        load = 1'b0;
        clr  = 1'b0;
        unique case (state_q)
            ST_GATE:  gate = 1'b1;
            ST_LOAD:  load = 1'b1;
            ST_CLEAR: clr  = 1'b1;
            default: ;
        endcase
    end

    assert_load_one_cycle_R3: assert property (@(posedge clk) disable iff (!rst_n)
        load |=> !load);
    assert_load_after_gate_R3: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(load) |-> $past(gate));
    assert_clear_follows_load_R4: assert property (@(posedge clk) disable iff (!rst_n)
        load |=> (clr && !gate));
    assert_clear_released_R4: assert property (@(posedge clk) disable iff (!rst_n)
        clr |=> (!clr && !gate));
    assert_phases_exclusive_R2: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({gate, load, clr}));
endmodule

// File: rtl/fgm_edge_sync.sv
module fgm_edge_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic din,
    output logic rise
);
    logic [STAGES-1:0] sync_q;
    logic              prev_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sync_q <= '0;
            prev_q <= 1'b0;
        end else begin
            sync_q <= {sync_q[STAGES-2:0], din};
            prev_q <= sync_q[STAGES-1];
        end
    end

    assign rise = sync_q[STAGES-1] & ~prev_q;

    assert_rise_single_R10: assert property (@(posedge clk) disable iff (!rst_n)
        rise |=> !rise);
endmodule

// File: rtl/fgm_bcd_digit.sv
module fgm_bcd_digit (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       clr,
    input  logic       cin,
    output logic [3:0] digit,
    output logic       cout
);
    localparam logic [3:0] TOP = 4'd9;

    assign cout = cin && (digit == TOP);

    always_ff @(posedge clk) begin
        if (!rst_n)       digit <= '0;
        else if (clr)     digit <= '0;
        else if (cin)     digit <= (digit == TOP) ? 4'd0 : digit + 4'd1;
    end

    assert_digit_range_R8: assert property (@(posedge clk) disable iff (!rst_n)
        digit <= TOP);
    assert_carry_single_R8: assert property (@(posedge clk) disable iff (!rst_n)
        cout |=> (!cout && digit == 4'd0));
endmodule

// File: rtl/freq_gate_meter.sv
module freq_gate_meter #(
    parameter int DIGITS      = 8,
    parameter int SYNC_STAGES = 2
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  sig_in,
    input  logic                  tick_1hz,
    output logic                  gate_en,
    output logic                  load_strobe,
    output logic                  clear_cnt,
    output logic [4*DIGITS-1:0]   result
);
    localparam int W = 4 * DIGITS;
    localparam logic [W-1:0] ALL_NINES = {DIGITS{4'h9}};

    logic          rise;
    logic          all_nine;
    logic [DIGITS:0] carry;
    logic [W-1:0]  count;

    fgm_gate_ctrl u_ctrl (
        .clk   (clk),
        .rst_n (rst_n),
        .tick  (tick_1hz),
        .gate  (gate_en),
        .load  (load_strobe),
        .clr   (clear_cnt)
    );

    fgm_edge_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .din   (sig_in),
        .rise  (rise)
    );

    assign all_nine = (count == ALL_NINES);
    assign carry[0] = rise & gate_en & ~all_nine;

    for (genvar i = 0; i < DIGITS; i++) begin : g_digit
        fgm_bcd_digit u_dig (
            .clk   (clk),
            .rst_n (rst_n),
            .clr   (clear_cnt),
            .cin   (carry[i]),
            .digit (count[4*i +: 4]),
            .cout  (carry[i+1])
        );
    end

    always_ff @(posedge clk) begin
        if (!rst_n)           result <= '0;
        else if (load_strobe) result <= count;
    end

    assert_no_count_closed_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (!gate_en && !clear_cnt) |=> $stable(count));
    assert_hold_between_loads_R7: assert property (@(posedge clk) disable iff (!rst_n)
        !load_strobe |=> $stable(result));
    assert_saturate_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (all_nine && !clear_cnt) |=> (count == ALL_NINES));
    assert_no_overflow_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !carry[DIGITS]);
endmodule

// File: tb/freq_gate_meter_bench.sv
module freq_gate_meter_bench;
    localparam int CLK_PERIOD = 10;
    localparam int NVEC = 10;
    localparam int VEC_CNT [0:NVEC-1] = '{0, 1, 7, 9, 10, 11, 99, 100, 1009, 105};
    localparam int VEC_WID [0:NVEC-1] = '{1, 1, 2, 1, 3, 1, 1, 2, 1, 6};

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic sig_in = 1'b0;
    logic tick = 1'b0;
    logic gate_en, load_strobe, clear_cnt;
    logic [31:0] result;
    logic s_gate, s_load, s_clr;
    logic [7:0] s_result;

    int errors = 0;
    int checks = 0;
    int cycles = 0;
    int prev_big = 0;
    int prev_small = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    freq_gate_meter u_freq_gate_meter (
        .clk(clk), .rst_n(rst_n), .sig_in(sig_in), .tick_1hz(tick),
        .gate_en(gate_en), .load_strobe(load_strobe), .clear_cnt(clear_cnt),
        .result(result)
    );

    freq_gate_meter #(.DIGITS(2)) u_small (
        .clk(clk), .rst_n(rst_n), .sig_in(sig_in), .tick_1hz(tick),
        .gate_en(s_gate), .load_strobe(s_load), .clear_cnt(s_clr),
        .result(s_result)
    );

    function automatic logic [31:0] to_bcd(int n, int digits);
        logic [31:0] v = '0;
        int lim = 1;
        for (int i = 0; i < digits; i++) lim = lim * 10;
        if (n > lim - 1) n = lim - 1;
        for (int i = 0; i < digits; i++) begin
            v[4*i +: 4] = 4'(n % 10);
            n = n / 10;
        end
        return v;
    endfunction

    task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic pulse_sig(int wid);
        sig_in = 1'b1;
        repeat (wid) @(negedge clk);
        sig_in = 1'b0;
        repeat (3) @(negedge clk);
    endtask

    task automatic send_tick();
        tick = 1'b1;
        @(negedge clk);
        tick = 1'b0;
    endtask

    task automatic window(int n, int wid);
        @(negedge clk);
        send_tick();
        check("R2 gate opens after tick", 32'(gate_en), 32'd1);
        repeat (3) @(negedge clk);
        for (int k = 0; k < n; k++) pulse_sig(wid);
        repeat (4) @(negedge clk);
        check("R2 gate held until tick", 32'(gate_en), 32'd1);
        check("R7 result held during gate", result, to_bcd(prev_big, 8));
        send_tick();
        check("R3 gate falls", 32'(gate_en), 32'd0);
        check("R3 load strobe", 32'(load_strobe), 32'd1);
        check("R3 no clear with load", 32'(clear_cnt), 32'd0);
        check("R7 result before load edge", result, to_bcd(prev_big, 8));
        @(negedge clk);
        check("R4 clear after load", {30'd0, load_strobe, clear_cnt}, 32'd1);
        check("R6 R8 count value", result, to_bcd(n, 8));
        check("R9 saturating count", 32'(s_result), to_bcd(n, 2));
        @(negedge clk);
        check("R4 clear released", {29'd0, gate_en, load_strobe, clear_cnt}, 32'd0);
        prev_big = n;
        prev_small = n;
        for (int k = 0; k < 3; k++) pulse_sig(2);
        check("R5 R7 result stable in closed phase", result, to_bcd(prev_big, 8));
        check("R5 gate closed", 32'(gate_en), 32'd0);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        errors++;
        checks++;
        $display("FAIL watchdog: actual=timeout expected=finish");
        $display("  Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    always @(posedge clk) cycles++;

    initial begin
        repeat (3) @(negedge clk);
        check("R1 result zero in reset", result, 32'd0);
        check("R1 controls low in reset", {29'd0, gate_en, load_strobe, clear_cnt}, 32'd0);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);
        pulse_sig(1);
        repeat (3) @(negedge clk);
        check("R1 idle until tick", {29'd0, gate_en, load_strobe, clear_cnt}, 32'd0);
        check("R1 result zero after reset", result, 32'd0);

        for (int v = 0; v < NVEC; v++) window(VEC_CNT[v], VEC_WID[v]);

        // R10: one long high pulse spanning many cycles counts once
        @(negedge clk);
        send_tick();
        repeat (3) @(negedge clk);
        pulse_sig(40);
        pulse_sig(1);
        repeat (4) @(negedge clk);
        send_tick();
        @(negedge clk);
        check("R10 long high counted once", result, to_bcd(2, 8));
        prev_big = 2;

        // R1: reset in mid-gate returns everything to zero and idle
        @(negedge clk);
        send_tick();
        pulse_sig(1);
        rst_n = 1'b0;
        @(negedge clk);
        check("R1 reset mid-gate clears result", result, 32'd0);
        rst_n = 1'b1;
        repeat (3) @(negedge clk);
        check("R1 idle after reset", 32'(gate_en), 32'd0);

        $display("  Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule